// File: doc/BRIEF.md
# Configuration Access Request Engine

This block lets software issue configuration reads and writes toward a link-side completer, one request at a time. Software first fills in a set of control registers: the transaction kind, a packed target address, the write data and the byte strobes. It then sets the go bit. The engine presents the programmed request on a request/response port and holds it there until the completer returns a response. At that point it records the 3-bit completion code and, for reads, the returned dword. It then clears the go bit and raises a done flag.

Software polls for completion: the go bit reads 0 and the done flag reads 1. Before the next request it writes 0 to go and writes 1 to done, which clears the flag. The engine does not shape data by access size. Software supplies strobes and data that are already shifted for the byte offset. It also extracts the bytes it wants from the returned dword.

Top module: `cfg_access_engine`

## Requirements
- R1: After reset, the engine is in this state: go reads 0, done reads 0, status reads 0, the read-data register reads 0xFFFFFFFF and `req_valid` is 0.
- R2: The target-address register stores bus in bits 27:20, device in bits 19:15, function in bits 14:12 and register offset in bits 11:2. Bits 1:0 are always stored as zero. The upper-address register stores any value and reads it back, but the value never reaches `req_addr`.
- R3: Writing a value with bit 0 set to go while idle sets `req_valid` on the following cycle. `req_kind` carries the kind field (bits 3:0 at word 0). The codes are 0x8 = type-0 read, 0x9 = type-1 read, 0xA = type-0 write and 0xB = type-1 write. `req_addr`, `req_wdata` and `req_strb` carry their registers, and go reads 1.
- R4: While a request is in flight, writes to go (either 0 or 1), kind, address, upper address, write data and strobe registers are ignored. The request outputs hold steady until the response.
- R5: A response is accepted in a cycle where `req_valid` and `rsp_valid` are both high. On the next cycle `req_valid` is 0, go reads 0 and done reads 1. The status register holds the completion code in bits 9:7 (0 OK, 1 unsupported, 2 retry, 4 abort) and has bit 0 set, which marks a non-posted request.
- R6: On a read that completes with code 0, the returned dword is captured into the read-data register. On any nonzero code the register becomes 0xFFFFFFFF. A write that completes with code 0 leaves the register unchanged.
- R7: Writing 1 to bit 0 of done clears the flag. Writing 0 to it has no effect.
- R8: A `rsp_valid` pulse while idle changes no status, read data or done flag.
- R9: The strobe register keeps only its low 4 bits and drives `req_strb` unchanged. A write of N bytes at byte offset k uses strobe bits k..k+N-1 and data shifted left by 8*k. A read uses strobe 0xF, and its result is the dword shifted right by 8*k and masked to N bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 4 | Register word index (0 kind, 1 status, 2 addr, 3 upper addr, 4 wdata, 5 strobe, 6 rdata, 7 go, 8 done) |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| req_valid | output | 1 | Request in flight |
| req_kind | output | 4 | Transaction kind code |
| req_addr | output | 32 | Packed target address |
| req_wdata | output | 32 | Write data, pre-shifted |
| req_strb | output | 4 | Byte strobes |
| rsp_valid | input | 1 | Completer response pulse |
| rsp_status | input | 3 | Completion code |
| rsp_rdata | input | 32 | Returned dword |

## Verification
Requests are issued with all four kind codes, with bus, device and function values that differ from request to request, and with both one-byte and two-byte accesses at offsets 0, 2 and 3. This tells apart field packing errors from strobe and shift errors. Completion codes OK, unsupported, retry and abort are all used. This separates the read-data capture path from the all-ones path, and reads from writes. A response held off while software rewrites registers shows whether the in-flight request is protected. A stray response while idle shows whether state is guarded by the busy condition.

// File: rtl/cfg_access_engine.sv
module cfg_access_engine #(
  parameter int DW = 32,
  parameter int SW = DW / 8,
  parameter int KW = 4,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_we,
  input  logic [3:0]    csr_addr,
  input  logic [DW-1:0] csr_wdata,
  output logic [DW-1:0] csr_rdata,
  output logic          req_valid,
  output logic [KW-1:0] req_kind,
  output logic [DW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  output logic [SW-1:0] req_strb,
  input  logic          rsp_valid,
  input  logic [CW-1:0] rsp_status,
  input  logic [DW-1:0] rsp_rdata
);
  localparam logic [3:0] A_KIND = 4'd0, A_STAT = 4'd1, A_ADDR = 4'd2, A_ADDRHI = 4'd3,
                         A_WDATA = 4'd4, A_STRB = 4'd5, A_RDATA = 4'd6, A_GO = 4'd7,
                         A_DONE = 4'd8;
  localparam int CODE_LSB = 7;

  logic          busy, done_q, np_q;
  logic [KW-1:0] kind_q;
  logic [DW-1:0] addr_q, addr_hi_q, wdata_q, rdata_q;
  logic [SW-1:0] strb_q;
  logic [CW-1:0] code_q;

  wire prog_ok = csr_we && !busy;
  wire go_set  = prog_ok && csr_addr == A_GO && csr_wdata[0];
  wire accept  = busy && rsp_valid;
  wire is_read = !kind_q[1];
  wire clr_done = csr_we && csr_addr == A_DONE && csr_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q    <= '0;
      addr_q    <= '0;
      addr_hi_q <= '0;
      wdata_q   <= '0;
      strb_q    <= '0;
    end else if (prog_ok) begin
      case (csr_addr)
        A_KIND:   kind_q    <= csr_wdata[KW-1:0];
        A_ADDR:   addr_q    <= {csr_wdata[DW-1:2], 2'b00};
        A_ADDRHI: addr_hi_q <= csr_wdata;
        A_WDATA:  wdata_q   <= csr_wdata;
        A_STRB:   strb_q    <= csr_wdata[SW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done_q  <= 1'b0;
      np_q    <= 1'b0;
      code_q  <= '0;
      rdata_q <= '1;
    end else begin
      if (go_set) begin
        busy <= 1'b1;
        np_q <= 1'b1;
      end
      if (accept) begin
        busy   <= 1'b0;
        code_q <= rsp_status;
        if (rsp_status != '0)
          rdata_q <= '1;
        else if (is_read)
          rdata_q <= rsp_rdata;
      end
      if (accept)
        done_q <= 1'b1;
      else if (clr_done)
        done_q <= 1'b0;
    end
  end

  assign req_valid = busy;
  assign req_kind  = kind_q;
  assign req_addr  = addr_q;
  assign req_wdata = wdata_q;
  assign req_strb  = strb_q;

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      A_KIND:   csr_rdata[KW-1:0] = kind_q;
      A_STAT: begin
        csr_rdata[CODE_LSB +: CW] = code_q;
        csr_rdata[0] = np_q;
      end
      A_ADDR:   csr_rdata = addr_q;
      A_ADDRHI: csr_rdata = addr_hi_q;
      A_WDATA:  csr_rdata = wdata_q;
      A_STRB:   csr_rdata[SW-1:0] = strb_q;
      A_RDATA:  csr_rdata = rdata_q;
      A_GO:     csr_rdata[0] = busy;
      A_DONE:   csr_rdata[0] = done_q;
      default:  csr_rdata = '0;
    endcase
  end

  p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && csr_we && csr_addr == A_GO && csr_wdata[0]) |=> req_valid);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_valid) |=> (req_valid && $stable(req_addr) && $stable(req_kind)
                                   && $stable(req_wdata) && $stable(req_strb)));

  p_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_valid) |=> (!req_valid && done_q && code_q == $past(rsp_status)));

  p_fail_rdata_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_valid && rsp_status != '0) |=> rdata_q == '1);

  p_stray_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && rsp_valid && !csr_we) |=> ($stable(code_q) && $stable(rdata_q) && $stable(done_q)));
endmodule

// File: tb/sim_cfg_access_engine.sv
`timescale 1ns/1ps
module sim_cfg_access_engine;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        csr_we = 0;
  logic [3:0]  csr_addr = 0;
  logic [31:0] csr_wdata = 0;
  logic [31:0] csr_rdata;
  logic        req_valid;
  logic [3:0]  req_kind;
  logic [31:0] req_addr, req_wdata;
  logic [3:0]  req_strb;
  logic        rsp_valid = 0;
  logic [2:0]  rsp_status = 0;
  logic [31:0] rsp_rdata = 0;

  int checks = 0, errors = 0;
  logic [71:0] exp_q[$];
  bit hold_rsp = 0, stray = 0, seen = 0;
  int lat = 0, cnt = 0;
  logic [2:0]  cfg_code = 0;
  logic [31:0] cfg_data = 0;

  cfg_access_engine u0 (.*);

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); csr_addr = a; #1 d = csr_rdata;
  endtask

  function automatic logic [31:0] pack(int bus, int dev, int fn, int off);
    return ((bus & 32'hff) << 20) | ((dev & 32'h1f) << 15) | ((fn & 32'h7) << 12) | (off & 32'hffc);
  endfunction

  // completer model and scoreboard monitor
  always @(negedge clk) begin
    rsp_valid = 0;
    if (stray && !req_valid) begin
      rsp_valid = 1; rsp_status = 3'd4; rsp_rdata = 32'h0BAD_F00D; stray = 0;
    end else if (req_valid && !seen) begin
      logic [71:0] e;
      seen = 1; cnt = lat;
      if (exp_q.size() == 0) begin
        checks++; errors++; $display("FAIL R3 unexpected request actual %h expected none", req_addr);
      end else begin
        e = exp_q.pop_front();
        chk("R3 kind", {28'b0, req_kind}, {28'b0, e[71:68]});
        chk("R2 addr", req_addr, e[67:36]);
        chk("R9 wdata", req_wdata, e[35:4]);
        chk("R9 strb", {28'b0, req_strb}, {28'b0, e[3:0]});
      end
    end else if (seen && !hold_rsp) begin
      if (cnt == 0) begin
        rsp_valid = 1; rsp_status = cfg_code; rsp_rdata = cfg_data; seen = 0;
      end else cnt--;
    end
  end

  task automatic wait_done();
    logic [31:0] d;
    for (int i = 0; i < 100; i++) begin
      rd(4'd8, d);
      if (d[0]) break;
    end
  endtask

  // program, launch, wait, then check go/done/status
  task automatic access(logic [3:0] kind, logic [31:0] a, logic [31:0] wd, logic [3:0] st,
                        logic [2:0] code, logic [31:0] data);
    logic [31:0] d;
    wr(4'd7, 0); wr(4'd8, 1);
    wr(4'd0, {28'b0, kind}); wr(4'd2, a); wr(4'd4, wd); wr(4'd5, {28'b0, st});
    cfg_code = code; cfg_data = data;
    exp_q.push_back({kind, a, wd, st});
    wr(4'd7, 1);
    wait_done();
    rd(4'd7, d); chk("R5 go cleared", d, 0);
    rd(4'd8, d); chk("R5 done set", d, 1);
    rd(4'd1, d); chk("R5 status", d, {22'b0, code, 6'b0, 1'b1});
    chk("R5 req_valid low", {31'b0, req_valid}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(4'd7, d); chk("R1 go", d, 0);
    rd(4'd8, d); chk("R1 done", d, 0);
    rd(4'd1, d); chk("R1 status", d, 0);
    rd(4'd6, d); chk("R1 rdata", d, 32'hFFFF_FFFF);
    chk("R1 req_valid", {31'b0, req_valid}, 0);

    wr(4'd2, 32'h0123_4567); rd(4'd2, d); chk("R2 low bits zero", d, 32'h0123_4564);
    wr(4'd3, 32'h5); rd(4'd3, d); chk("R2 upper stored", d, 32'h5);
    wr(4'd5, 32'hFF); rd(4'd5, d); chk("R9 strobe width", d, 32'hF);

    // type-0 read, one byte at offset 2
    a = pack(0, 0, 0, 'h12);
    access(4'h8, a, 0, 4'hF, 3'd0, 32'hAABB_CCDD);
    rd(4'd6, d); chk("R6 read captured", d, 32'hAABB_CCDD);
    chk("R9 byte extract", (d >> 16) & 32'hFF, 32'hBB);

    // type-1 read, two bytes at offset 2
    a = pack(3, 5, 2, 'h46);
    access(4'h9, a, 0, 4'hF, 3'd0, 32'h1234_5678);
    rd(4'd6, d); chk("R9 half extract", (d >> 16) & 32'hFFFF, 32'h1234);

    // type-0 write, one byte at offset 3
    a = pack(1, 31, 7, 'hFF);
    access(4'hA, a, 32'h5A << 24, 4'b0001 << 3, 3'd0, 32'hDEAD_BEEF);
    rd(4'd6, d); chk("R6 write keeps rdata", d, 32'h1234_5678);

    // type-1 write, two bytes at offset 0, aborted
    a = pack(255, 1, 1, 'h100);
    access(4'hB, a, 32'h0000_BEEF, 4'b0011, 3'd4, 0);
    rd(4'd6, d); chk("R6 abort all ones", d, 32'hFFFF_FFFF);

    // successful read again, then unsupported and retry reads
    access(4'h8, pack(0, 0, 0, 0), 0, 4'hF, 3'd0, 32'h0000_1AB4);
    rd(4'd6, d); chk("R6 read captured", d, 32'h0000_1AB4);
    access(4'h9, pack(2, 0, 0, 8), 0, 4'hF, 3'd1, 32'h1111_1111);
    rd(4'd6, d); chk("R6 unsupported all ones", d, 32'hFFFF_FFFF);
    access(4'h9, pack(2, 0, 0, 8), 0, 4'hF, 3'd2, 32'h2222_2222);
    rd(4'd6, d); chk("R6 retry all ones", d, 32'hFFFF_FFFF);

    // in-flight protection
    wr(4'd7, 0); wr(4'd8, 1);
    a = pack(9, 9, 1, 'h20);
    wr(4'd0, 4'h8); wr(4'd2, a); wr(4'd4, 0); wr(4'd5, 4'hF);
    hold_rsp = 1; cfg_code = 0; cfg_data = 32'hCAFE_0001;
    exp_q.push_back({4'h8, a, 32'h0, 4'hF});
    wr(4'd7, 1);
    wr(4'd7, 1);
    wr(4'd7, 0);
    wr(4'd2, pack(7, 7, 7, 'h40));
    wr(4'd0, 4'hB);
    wr(4'd3, 32'h9);
    rd(4'd7, d); chk("R4 go held", d, 1);
    rd(4'd2, d); chk("R4 addr held", d, a);
    rd(4'd3, d); chk("R4 upper held", d, 32'h5);
    chk("R4 req_addr stable", req_addr, a);
    chk("R4 req_kind stable", {28'b0, req_kind}, 32'h8);
    hold_rsp = 0;
    wait_done();
    rd(4'd6, d); chk("R4 completes", d, 32'hCAFE_0001);

    // done flag clearing
    wr(4'd8, 0); rd(4'd8, d); chk("R7 write zero ignored", d, 1);
    wr(4'd8, 1); rd(4'd8, d); chk("R7 cleared", d, 0);

    // stray response while idle
    wr(4'd7, 0);
    stray = 1;
    repeat (4) @(negedge clk);
    rd(4'd1, d); chk("R8 status kept", d, {22'b0, 3'd0, 6'b0, 1'b1});
    rd(4'd6, d); chk("R8 rdata kept", d, 32'hCAFE_0001);
    rd(4'd8, d); chk("R8 done kept", d, 0);
    chk("R8 req_valid low", {31'b0, req_valid}, 0);
    chk("R3 all requests seen", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule